// File: doc/BRIEF.md
# PRBS Lock Checker

This block watches a stream of sample words from one converter channel while the converter sends a test pattern. It compares each word with the next word of a locally generated pseudo-random sequence and tracks whether the stream is locked to that sequence. Two sequence families are supported, chosen by a select field. While the checker is out of lock it reloads its generator from the received bits on every sample, so it can find the pattern again after a slip or after a restart.

Lock state has hysteresis. A long run of consecutive bad words is needed to declare loss of lock, and a shorter run of consecutive good words is needed to regain it. Once locked, the generator runs on its own predictions, so a single corrupted word shows up as an isolated error and not as a lost lock. Two sticky flags report to the surrounding register logic. Each is cleared by a one-cycle clear pulse. Errors are only reported while locked.

Top module: `prbs_lock_checker`

## Requirements
- R1: Reset (rst_n low at a clock edge) leaves oos_state=1, oos_flag=1, err_flag=0 and sample_mismatch=0.
- R2: seq_sel=0 selects the 9-bit sequence b[n]=b[n-9]^b[n-5]. Any other value selects the 23-bit sequence b[n]=b[n-23]^b[n-18]. Each word holds DW successive bits, with the earliest bit in the MSB.
- R3: While out of lock, the generator is reloaded from the received word on every valid sample. oos_state clears on the 16th consecutive matching sample. For a clean 9-bit stream after reset that is the 17th sample.
- R4: While locked, oos_state sets on the 64th consecutive mismatching sample. A single matching sample restarts that count.
- R5: A mismatching valid sample while locked sets err_flag. err_flag then stays set until clr_err is high. If a new error and clr_err occur in the same cycle, err_flag stays set.
- R6: err_flag is cleared when lock is lost, and it is never set while oos_state is 1.
- R7: oos_flag is 1 whenever oos_state is 1. It stays 1 after lock is regained until clr_oos is high. clr_oos has no effect while oos_state is 1.
- R8: Any change of seq_sel forces oos_state to 1 in the next cycle and restarts the count of matching samples.
- R9: A cycle with in_valid low changes neither the lock state, the counters, the generator nor the flags (apart from a clear pulse).
- R10: sample_mismatch is 1 in the cycle after a valid sample that differed from the prediction, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Received sample word |
| seq_sel | input | SELW | Sequence select (0: 9-bit, else 23-bit) |
| clr_oos | input | 1 | Clear pulse for oos_flag |
| clr_err | input | 1 | Clear pulse for err_flag |
| oos_state | output | 1 | Live out-of-lock state |
| oos_flag | output | 1 | Sticky out-of-lock flag |
| err_flag | output | 1 | Sticky error flag |
| sample_mismatch | output | 1 | Last valid sample mismatched |

## Verification
Two pairs of events can land in the same cycle. The first pair is an error setting err_flag while a clear pulse arrives. The bench drives a corrupted word together with clr_err and expects the flag to stay set. The second pair is loss of lock and error reporting. On the 64th corrupted word the bench expects err_flag to drop in the same cycle that oos_state rises, and it expects the flag to stay low through the corrupted words that follow.

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker #(
  parameter int DW       = 16,
  parameter int SELW     = 4,
  parameter int LOSE_CNT = 64,
  parameter int GAIN_CNT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic [SELW-1:0] seq_sel,
  input  logic            clr_oos,
  input  logic            clr_err,
  output logic            oos_state,
  output logic            oos_flag,
  output logic            err_flag,
  output logic            sample_mismatch
);
  localparam int HW = 23;
  localparam int MW = $clog2(LOSE_CNT);
  localparam int GW = $clog2(GAIN_CNT);

  logic [HW-1:0]   hist_q, hist_nx, run_h, rx_h;
  logic [DW-1:0]   pred;
  logic [SELW-1:0] sel_q;
  logic [MW-1:0]   miss_q, miss_nx;
  logic [GW-1:0]   hit_q, hit_nx;
  logic            oos_q, oos_nx, err_q, oosf_q, mis_q;
  logic            short_seq, sel_chg, mism, err_set;

  assign short_seq = (seq_sel == '0);
  assign sel_chg   = (seq_sel != sel_q);

  always_comb begin
    logic [HW-1:0] h;
    logic          nb;
    h = hist_q;
    for (int i = DW - 1; i >= 0; i--) begin
      nb = short_seq ? (h[8] ^ h[4]) : (h[22] ^ h[17]);
      pred[i] = nb;
      h = {h[HW-2:0], nb};
    end
    run_h = h;
  end

  always_comb begin
    logic [HW-1:0] h;
    h = hist_q;
    for (int i = DW - 1; i >= 0; i--) h = {h[HW-2:0], in_data[i]};
    rx_h = h;
  end

  assign mism = (in_data != pred);

  always_comb begin
    oos_nx  = oos_q;
    hit_nx  = hit_q;
    miss_nx = miss_q;
    hist_nx = hist_q;
    if (sel_chg) begin
      oos_nx  = 1'b1;
      hit_nx  = '0;
      miss_nx = '0;
      if (in_valid) hist_nx = rx_h;
    end else if (in_valid) begin
      if (oos_q) begin
        hist_nx = rx_h;
        if (mism) hit_nx = '0;
        else if (hit_q == GW'(GAIN_CNT - 1)) begin
          oos_nx  = 1'b0;
          hit_nx  = '0;
          miss_nx = '0;
        end else hit_nx = hit_q + 1'b1;
      end else begin
        hist_nx = run_h;
        if (!mism) miss_nx = '0;
        else if (miss_q == MW'(LOSE_CNT - 1)) begin
          oos_nx  = 1'b1;
          miss_nx = '0;
          hit_nx  = '0;
        end else miss_nx = miss_q + 1'b1;
      end
    end
  end

  assign err_set = in_valid & mism & ~oos_q & ~sel_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      sel_q  <= '0;
      miss_q <= '0;
      hit_q  <= '0;
      oos_q  <= 1'b1;
      oosf_q <= 1'b1;
      err_q  <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      hist_q <= hist_nx;
      sel_q  <= seq_sel;
      miss_q <= miss_nx;
      hit_q  <= hit_nx;
      oos_q  <= oos_nx;
      oosf_q <= oos_nx | (oosf_q & ~clr_oos);
      err_q  <= ~oos_nx & (err_set | (err_q & ~clr_err));
      mis_q  <= in_valid & mism;
    end
  end

  assign oos_state       = oos_q;
  assign oos_flag        = oosf_q;
  assign err_flag        = err_q;
  assign sample_mismatch = mis_q;

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && seq_sel == sel_q) |=> $stable(oos_state));
  // R3
  regain_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oos_state) |-> $past(in_valid));
  // R7
  flag_covers_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oos_state |-> oos_flag);
  // R6
  err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (!oos_state && $past(in_valid)));
  // R8
  sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel != sel_q) |=> oos_state);
endmodule

// File: tb/prbs_lock_checker_tb.sv
module prbs_lock_checker_tb;
  localparam int PERIOD = 10;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0, in_valid = 0, clr_oos = 0, clr_err = 0;
  logic [DW-1:0] in_data = '0;
  logic [3:0] seq_sel = '0;
  logic oos_state, oos_flag, err_flag, sample_mismatch;
  logic [22:0] bh = '1;
  int checks = 0, errors = 0;

  prbs_lock_checker #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .seq_sel(seq_sel), .clr_oos(clr_oos), .clr_err(clr_err),
    .oos_state(oos_state), .oos_flag(oos_flag), .err_flag(err_flag),
    .sample_mismatch(sample_mismatch));

  always #(PERIOD/2) clk = ~clk;

  // rows: {count[7:0], corrupt, exp_oos_state, exp_err, exp_oos_flag}
  localparam logic [11:0] TBL [13] = '{
    {8'd1,  4'b0101}, {8'd15, 4'b0101}, {8'd1,  4'b0001}, {8'd4,  4'b0001},
    {8'd1,  4'b1011}, {8'd2,  4'b0011}, {8'd63, 4'b1011}, {8'd1,  4'b0011},
    {8'd63, 4'b1011}, {8'd1,  4'b1101}, {8'd5,  4'b1101}, {8'd16, 4'b0101},
    {8'd1,  4'b0001}};
  localparam string TREQ [13] = '{"R3", "R3", "R3", "R3", "R5", "R5", "R4",
    "R4", "R4", "R6", "R6", "R3", "R3"};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] next_word();
    logic [DW-1:0] w;
    logic nb;
    for (int i = DW - 1; i >= 0; i--) begin
      nb = (seq_sel == 0) ? (bh[8] ^ bh[4]) : (bh[22] ^ bh[17]);
      w[i] = nb;
      bh = {bh[21:0], nb};
    end
    return w;
  endfunction

  task automatic send(input logic bad, input logic ce);
    in_valid = 1;
    in_data = next_word() ^ DW'(bad);
    clr_err = ce;
    @(negedge clk);
    in_valid = 0;
    clr_err = 0;
  endtask

  task automatic sendn(input int n, input logic bad);
    for (int k = 0; k < n; k++) send(bad, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check("R1", oos_state, 1);
    check("R1", oos_flag, 1);
    check("R1", err_flag, 0);
    check("R1", sample_mismatch, 0);
    rst_n = 1;
    idle(1);

    for (int r = 0; r < 13; r++) begin
      sendn(int'(TBL[r][11:4]), TBL[r][3]);
      check(TREQ[r], oos_state, TBL[r][2]);
      check(TREQ[r], err_flag, TBL[r][1]);
      check(TREQ[r], oos_flag, TBL[r][0]);
    end

    // R7: sticky flag survives lock, cleared by pulse
    clr_oos = 1; idle(1); clr_oos = 0;
    check("R7", oos_flag, 0);

    // R5 / R10
    send(1, 0);
    check("R5", err_flag, 1);
    check("R10", sample_mismatch, 1);
    send(0, 0);
    check("R10", sample_mismatch, 0);
    check("R5", err_flag, 1);
    clr_err = 1; idle(1); clr_err = 0;
    check("R5", err_flag, 0);
    send(1, 1);
    check("R5", err_flag, 1);
    clr_err = 1; idle(1); clr_err = 0;
    check("R5", err_flag, 0);

    // R9: garbage with valid low
    in_data = 16'hDEAD;
    idle(5);
    check("R9", oos_state, 0);
    check("R9", err_flag, 0);
    check("R9", sample_mismatch, 0);
    sendn(3, 0);
    check("R9", err_flag, 0);
    check("R9", oos_state, 0);

    // R8: select change forces out of lock
    seq_sel = 4'd5; idle(1);
    check("R8", oos_state, 1);
    check("R7", oos_flag, 1);
    clr_oos = 1; seq_sel = 4'd0; idle(1); clr_oos = 0;
    check("R7", oos_flag, 1);
    sendn(10, 0);
    check("R8", oos_state, 1);
    seq_sel = 4'd5; idle(1); seq_sel = 4'd0; idle(1);
    sendn(15, 0);
    check("R8", oos_state, 1);
    sendn(1, 0);
    check("R8", oos_state, 0);
    check("R6", err_flag, 0);

    // R2: 23-bit family
    seq_sel = 4'd3; idle(1);
    sendn(15, 0);
    check("R2", oos_state, 1);
    sendn(3, 0);
    check("R2", oos_state, 0);
    sendn(20, 0);
    check("R2", err_flag, 0);
    check("R2", sample_mismatch, 0);

    // R1: reset mid-run
    send(1, 0);
    check("R5", err_flag, 1);
    rst_n = 0; idle(1);
    check("R1", oos_state, 1);
    check("R1", oos_flag, 1);
    check("R1", err_flag, 0);
    check("R1", sample_mismatch, 0);
    rst_n = 1; idle(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule